// File: doc/BRIEF.md
# Interleaved I/Q Polyphase CIC Decimator

This block reduces the sample rate of a complex baseband stream by 32. It is built from adders, subtractors and registers only. It has no multipliers and no coefficient storage. Each active input cycle carries one in-phase sample and one quadrature sample, both 19 bits. A polyphase front stage spreads each channel's stream over four subfilter lanes. When the fourth lane is filled, the front stage adds the lanes to form one boxcar-of-four sample per channel. Everything after this point therefore runs at one quarter of the input rate.

A single four-stage integrator-comb section (differential delay one, further decimation by eight) is shared between the two channels. Every integrator and every comb keeps one register for I and one for Q. A small sequencer feeds the I front sum through the section in one cycle and the Q front sum in the next cycle. The per-channel registers make the result identical to two separate filters. Arithmetic inside the section is 39-bit two's complement and wraps without saturation. Each output is the upper 19 bits of the 39-bit comb result.

The sequencer has three states:
- `ST_IDLE` waits for a front sum.
- `ST_CH_I` runs the I word through the section.
- `ST_CH_Q` runs the Q word.

Its transitions are:
- idle-to-I when a front sum is ready.
- I-to-Q, which is unconditional.
- Q-to-I when another front sum is already waiting.
- Q-to-idle otherwise.

Top module: `iq_cic_decim`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes low. The lane phase, decimation count, fill count and every integrator and comb register are cleared, so no history from before reset reaches a later output.
- R2: The front stage forms, per channel, the sum of each group of four consecutive accepted samples, counted from reset. The result is sign-extended to 39 bits.
- R3: Each output equals the upper 19 bits (bits 38 down to 20) of a four-stage cascaded integrator, decimate-by-8, four-stage comb chain. That chain runs on the front sums of its own channel in 39-bit two's-complement arithmetic.
- R4: I and Q are processed independently. An output of one channel does not depend on the samples of the other.
- R5: Outputs come in pairs on consecutive cycles. The I word comes first with `out_q_flag` = 0, and the Q word follows with `out_q_flag` = 1. No third pulse follows a Q pulse directly.
- R6: One output pair is produced for every 32 accepted input pairs after fill. Two pairs are never closer than 30 cycles apart.
- R7: The first four decimated pairs after reset are withheld while the comb delays fill. The first output therefore follows no earlier than the 160th accepted input pair.
- R8: For a constant input x, the steady-state output is x arithmetically shifted right by 6, since the DC gain of 2^14 is followed by a 20-bit truncation. For example, 100000 gives 1562 and -100000 gives -1563.
- R9: Integrators wrap modulo 2^39 with no saturation. A sustained full-scale input of -262144 still settles to -4096.
- R10: `out_data` holds its value in every cycle where `out_valid` is low.
- R11: Cycles with `in_valid` low are ignored. Idle gaps between accepted samples do not change any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair accepted this cycle |
| in_i | input | 19 | In-phase sample, two's complement |
| in_q | input | 19 | Quadrature sample, two's complement |
| out_valid | output | 1 | One decimated word present |
| out_q_flag | output | 1 | 0 = word is I, 1 = word is Q |
| out_data | output | 19 | Decimated word, two's complement |

## Verification
The properties assume that `in_valid` is a known level, that each high cycle carries exactly one I/Q pair, and that reset is held for at least two edges. The gap and fill counters in the checker count accepted pairs on this basis. The stimulus uses a multi-cycle reset and drives at most one pair per cycle. Idle cycles are inserted only between pairs. The inputs stay within the 19-bit signed range, including both full-scale extremes.

// File: rtl/iqcic_pkg.sv
package iqcic_pkg;

    // Sequencer states of the shared integrator-comb section
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CH_I = 2'd1,
        ST_CH_Q = 2'd2
    } seq_state_t;

endpackage

// File: rtl/iqcic_front.sv
// Polyphase front stage: FRONT lanes per channel, summed on the last phase.
module iqcic_front #(
    parameter int IN_W  = 19,
    parameter int ACC_W = 39,
    parameter int FRONT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    output logic                    sum_valid,
    output logic signed [ACC_W-1:0] sum_i,
    output logic signed [ACC_W-1:0] sum_q
);
    localparam int PH_W  = (FRONT > 1) ? $clog2(FRONT) : 1;
    localparam int EXT_W = ACC_W - IN_W;
    localparam int LANES = FRONT - 1;

    logic [PH_W-1:0]         phase;
    logic                    last_ph;
    logic signed [ACC_W-1:0] ext_i, ext_q;
    logic signed [ACC_W-1:0] lane_i [LANES];
    logic signed [ACC_W-1:0] lane_q [LANES];
    logic signed [ACC_W-1:0] tot_i, tot_q;

    assign last_ph = (phase == PH_W'(FRONT - 1));
    assign ext_i   = {{EXT_W{in_i[IN_W-1]}}, in_i};
    assign ext_q   = {{EXT_W{in_q[IN_W-1]}}, in_q};

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (in_valid)
            phase <= last_ph ? '0 : phase + PH_W'(1);
    end

    // One subfilter lane per earlier phase, each updated once per group
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [ACC_W-1:0] held_i, held_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                held_i <= '0;
                held_q <= '0;
            end else if (in_valid && phase == PH_W'(g)) begin
                held_i <= ext_i;
                held_q <= ext_q;
            end
        end
        assign lane_i[g] = held_i;
        assign lane_q[g] = held_q;
    end

    always_comb begin
        tot_i = ext_i;
        tot_q = ext_q;
        for (int k = 0; k < LANES; k++) begin
            tot_i = tot_i + lane_i[k];
            tot_q = tot_q + lane_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_valid <= 1'b0;
            sum_i     <= '0;
            sum_q     <= '0;
        end else begin
            sum_valid <= in_valid && last_ph;
            if (in_valid && last_ph) begin
                sum_i <= tot_i;
                sum_q <= tot_q;
            end
        end
    end
endmodule

// File: rtl/iqcic_integ.sv
// Integrator cascade with one register pair (I, Q) per stage.
module iqcic_integ #(
    parameter int ACC_W  = 39,
    parameter int STAGES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    sel_q,
    input  logic signed [ACC_W-1:0] x,
    output logic signed [ACC_W-1:0] y
);
    logic signed [ACC_W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic signed [ACC_W-1:0] acc_i, acc_q, feed;
        if (g == 0) begin : g_head
            assign feed = x;
        end else begin : g_body
            assign feed = chain[g-1];
        end
        assign chain[g] = (sel_q ? acc_q : acc_i) + feed;
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_i <= '0;
                acc_q <= '0;
            end else if (en) begin
                if (sel_q)
                    acc_q <= chain[g];
                else
                    acc_i <= chain[g];
            end
        end
    end

    assign y = chain[STAGES-1];
endmodule

// File: rtl/iqcic_comb.sv
// Comb cascade (differential delay one) with per-channel delay registers.
module iqcic_comb #(
    parameter int ACC_W  = 39,
    parameter int OUT_W  = 19,
    parameter int STAGES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    sel_q,
    input  logic signed [ACC_W-1:0] x,
    output logic signed [OUT_W-1:0] y_top
);
    logic signed [ACC_W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic signed [ACC_W-1:0] dly_i, dly_q, feed;
        if (g == 0) begin : g_head
            assign feed = x;
        end else begin : g_body
            assign feed = chain[g-1];
        end
        assign chain[g] = feed - (sel_q ? dly_q : dly_i);
        always_ff @(posedge clk) begin
            if (rst) begin
                dly_i <= '0;
                dly_q <= '0;
            end else if (en) begin
                if (sel_q)
                    dly_q <= feed;
                else
                    dly_i <= feed;
            end
        end
    end

    assign y_top = chain[STAGES-1][ACC_W-1 -: OUT_W];
endmodule

// File: rtl/iq_cic_decim.sv
module iq_cic_decim #(
    parameter int IN_W   = 19,
    parameter int ACC_W  = 39,
    parameter int OUT_W  = 19,
    parameter int FRONT  = 4,
    parameter int REST   = 8,
    parameter int STAGES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic                   out_valid,
    output logic                   out_q_flag,
    output logic [OUT_W-1:0]       out_data
);
    import iqcic_pkg::*;

    localparam int DEC_W  = (REST > 1) ? $clog2(REST) : 1;
    localparam int FILL_W = $clog2(STAGES + 1);

    seq_state_t              state, nxt_state;
    logic                    sum_valid;
    logic signed [ACC_W-1:0] sum_i, sum_q;
    logic signed [ACC_W-1:0] sec_in, integ_y;
    logic signed [OUT_W-1:0] comb_top;
    logic [DEC_W-1:0]        dec_cnt;
    logic [FILL_W-1:0]       fill_cnt;
    logic                    busy, sel_q, dec_hit, comb_en, filled;

    iqcic_front #(.IN_W(IN_W), .ACC_W(ACC_W), .FRONT(FRONT)) u_front (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .sum_valid(sum_valid),
        .sum_i    (sum_i),
        .sum_q    (sum_q)
    );

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: if (sum_valid) nxt_state = ST_CH_I;
            ST_CH_I: nxt_state = ST_CH_Q;
            ST_CH_Q: nxt_state = sum_valid ? ST_CH_I : ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    assign busy    = (state == ST_CH_I) || (state == ST_CH_Q);
    assign sel_q   = (state == ST_CH_Q);
    assign sec_in  = sel_q ? sum_q : sum_i;
    assign dec_hit = (dec_cnt == DEC_W'(REST - 1));
    assign comb_en = busy && dec_hit;
    assign filled  = (fill_cnt == FILL_W'(STAGES));

    iqcic_integ #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .sel_q(sel_q),
        .x    (sec_in),
        .y    (integ_y)
    );

    iqcic_comb #(.ACC_W(ACC_W), .OUT_W(OUT_W), .STAGES(STAGES)) u_comb (
        .clk  (clk),
        .rst  (rst),
        .en   (comb_en),
        .sel_q(sel_q),
        .x    (integ_y),
        .y_top(comb_top)
    );

    // Decimation and fill counters advance once per I/Q pair
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_cnt  <= '0;
            fill_cnt <= '0;
        end else if (state == ST_CH_Q) begin
            dec_cnt <= dec_hit ? '0 : dec_cnt + DEC_W'(1);
            if (dec_hit && !filled)
                fill_cnt <= fill_cnt + FILL_W'(1);
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_q_flag <= 1'b0;
            out_data   <= '0;
        end else begin
            out_valid <= comb_en && filled;
            if (comb_en && filled) begin
                out_q_flag <= sel_q;
                out_data   <= comb_top;
            end
        end
    end
endmodule

// File: rtl/iqcic_chk.sv
module iqcic_chk #(
    parameter int OUT_W  = 19,
    parameter int FRONT  = 4,
    parameter int REST   = 8,
    parameter int STAGES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_q_flag,
    input logic [OUT_W-1:0] out_data
);
    localparam int FILL_IN = FRONT * REST * (STAGES + 1);
    localparam int CNT_W   = $clog2(FILL_IN + 1);
    localparam int PAIR    = FRONT * REST;
    localparam int GAP_MIN = PAIR - 2;
    localparam int GAP_W   = $clog2(PAIR + 1);

    logic [CNT_W-1:0] in_cnt;
    logic [GAP_W-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            in_cnt <= '0;
        else if (in_valid && in_cnt != CNT_W'(FILL_IN))
            in_cnt <= in_cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            gap_cnt <= GAP_W'(PAIR);
        else if (out_valid && out_q_flag)
            gap_cnt <= '0;
        else if (gap_cnt != GAP_W'(PAIR))
            gap_cnt <= gap_cnt + GAP_W'(1);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R5
    i_then_q_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_q_flag) |=> (out_valid && out_q_flag));

    // R5
    q_ends_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_q_flag) |=> !out_valid);

    // R6
    pair_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_q_flag) |-> (gap_cnt >= GAP_W'(GAP_MIN)));

    // R7
    fill_wait_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_cnt == CNT_W'(FILL_IN)));

    // R10
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
endmodule

bind iq_cic_decim iqcic_chk #(
    .OUT_W (OUT_W),
    .FRONT (FRONT),
    .REST  (REST),
    .STAGES(STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_q_flag(out_q_flag),
    .out_data  (out_data)
);

// File: tb/sim_iq_cic_decim.sv
`timescale 1ns/1ps
module sim_iq_cic_decim;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [18:0] in_i = '0;
    logic signed [18:0] in_q = '0;
    logic              out_valid;
    logic              out_q_flag;
    logic [18:0]       out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    iq_cic_decim u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_q_flag(out_q_flag), .out_data(out_data)
    );

    // ---------------- behavioural model: two separate filters -------------
    logic signed [38:0] m_int [2][4];
    logic signed [38:0] m_dly [2][4];
    logic signed [38:0] m_box [2];
    int m_ph, m_dec, m_fill, n_in;
    int  exp_val [$];
    bit  exp_flg [$];

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_box[c] = '0;
            for (int s = 0; s < 4; s++) begin
                m_int[c][s] = '0;
                m_dly[c][s] = '0;
            end
        end
        m_ph = 0; m_dec = 0; m_fill = 0; n_in = 0;
        exp_val.delete();
        exp_flg.delete();
    endtask

    task automatic model_push(input int vi, input int vq);
        logic signed [38:0] t, o;
        m_box[0] = m_box[0] + 39'(signed'(vi));
        m_box[1] = m_box[1] + 39'(signed'(vq));
        m_ph++;
        if (m_ph == 4) begin
            m_ph = 0;
            for (int c = 0; c < 2; c++) begin
                t = m_box[c];
                for (int s = 0; s < 4; s++) begin
                    m_int[c][s] = m_int[c][s] + t;
                    t = m_int[c][s];
                end
                m_box[c] = '0;
                if (m_dec == 7) begin
                    for (int s = 0; s < 4; s++) begin
                        o = t - m_dly[c][s];
                        m_dly[c][s] = t;
                        t = o;
                    end
                    if (m_fill >= 4) begin
                        exp_val.push_back(int'($signed(t[38:20])));
                        exp_flg.push_back(c[0]);
                    end
                end
            end
            if (m_dec == 7) begin
                m_dec = 0;
                m_fill++;
            end else begin
                m_dec++;
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- output monitor, sampled on falling edges -----------
    int  last_i, last_q, first_n;
    bit  seen, q_nonzero;
    logic [18:0] prev_data;

    always @(negedge clk) begin
        if (rst) begin
            check(out_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);
            seen = 1'b0;
        end else begin
            if (!out_valid)
                check(out_data == prev_data, "R10 data held", int'($signed(out_data)),
                      int'($signed(prev_data)));
            if (out_valid) begin
                if (!seen) begin
                    seen = 1'b1;
                    first_n = n_in;
                    check(n_in >= 160, "R7 first output after fill", n_in, 160);
                end
                if (exp_val.size() == 0) begin
                    check(1'b0, "R6 unexpected output", int'($signed(out_data)), 0);
                end else begin
                    check(out_q_flag == exp_flg[0], "R5 channel order",
                          int'(out_q_flag), int'(exp_flg[0]));
                    check($signed(out_data) == exp_val[0], "R3 R4 sample value",
                          int'($signed(out_data)), exp_val[0]);
                    void'(exp_val.pop_front());
                    void'(exp_flg.pop_front());
                end
                if (out_q_flag) begin
                    last_q = int'($signed(out_data));
                    if (last_q != 0) q_nonzero = 1'b1;
                end else begin
                    last_i = int'($signed(out_data));
                end
            end
        end
        prev_data = out_data;
    end

    // ---------------- stimulus helpers -----------------------------------
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        model_reset();
        q_nonzero = 1'b0;
        rst = 1'b0;
    endtask

    task automatic send(input int vi, input int vq, input int gap);
        in_valid = 1'b1;
        in_i = 19'(vi);
        in_q = 19'(vq);
        model_push(vi, vq);
        n_in++;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain();
        repeat (40) @(negedge clk);
        check(exp_val.size() == 0, "R6 pair count", exp_val.size(), 0);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: quiet after reset with no input
        repeat (10) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
        end

        // DC, continuous input: R2 R3 R8
        for (int k = 0; k < 400; k++) send(100000, -100000, 0);
        drain();
        check(last_i == 1562, "R8 DC gain on I", last_i, 1562);
        check(last_q == -1563, "R8 DC gain on Q", last_q, -1563);
        check(first_n <= 164, "R7 first output timing", first_n, 160);

        // Reset mid-stream, impulse on I only with idle gaps: R1 R4 R11
        do_reset();
        for (int k = 0; k < 400; k++) send((k == 0) ? 262143 : 0, 0, k % 3);
        drain();
        check(q_nonzero == 1'b0, "R4 R1 Q stays zero", int'(q_nonzero), 0);
        check(last_i == 0, "R11 impulse settles", last_i, 0);

        // Alternating full-scale I, full-scale negative Q: R9
        do_reset();
        for (int k = 0; k < 640; k++)
            send((k % 2 == 0) ? 262143 : -262144, -262144, (k % 5 == 0) ? 2 : 0);
        drain();
        check(last_q == -4096, "R9 wrap full scale", last_q, -4096);
        check(last_i == -1, "R2 R9 alternating input", last_i, -1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule